// File: doc/BRIEF.md
# Serial Flash Geometry Probe

This block runs once at start-up, or whenever it is asked again, to learn the layout of a page-buffered serial flash. It has a single-byte SPI master port. Over that port it sends an identification command and reads back a fixed number of ID bytes. When the manufacturer byte and density code match a known family, the block takes the page count from the density code. Some of these parts can run with either a binary page size or an extended page size. For those parts the block also reads the status byte, and bit 0 of that byte chooses between the two page sizes.

If the identification bytes match nothing, the block falls back to an older scheme. In that scheme the density is encoded in status bits 5:2. A status byte that is all zeros or all ones means no device is present.

The block outputs the following:
- page size in bytes
- page-address shift
- page count
- a binary-page flag
- total size
- erase granularity
- a two-bit result code

All of these are held, together with a done flag, until the next probe request.

Top module: `sfp_probe`

## Requirements
- R1: After reset, `probe_done` is 0, `probe_result` is 0 (none), every geometry output is 0 and `xfer_req` is 0.
- R2: An accepted probe first issues one frame. The frame is opcode 0x9F followed by ID_BYTES (default 5) fill bytes of 0x00. `xfer_end` is set only on the last byte of the frame. The first three bytes read back are kept as the identifier {byte0, byte1, byte2}.
- R3: `xfer_req`, `xfer_tx` and `xfer_end` stay unchanged until `xfer_ack`. Each `xfer_ack` completes exactly one byte, and `xfer_rx` is taken in that same cycle.
- R4: Some identifiers can use either page size: byte0 = 0x1F, byte2 = 0x00 with byte1 in {0x22..0x26, 0x28}, or byte1 = 0x27 with byte2 = 0x01. For these the block issues a second frame, opcode 0xD7 plus one fill byte, which returns the status. If status bit 0 is 1, the result is power-of-two pages:
  - 256 bytes with shift 8 for codes 0x22..0x25
  - 512 bytes with shift 9 for codes 0x26 and 0x27
  - 1024 bytes with shift 10 for code 0x28

  `pow2_pages` is 1 in this case. The page counts are 512, 1024, 2048, 4096, 4096, 8192 and 8192 for codes 0x22 through 0x28.
- R5: For the same identifiers, status bit 0 = 0 selects extended pages with `pow2_pages` = 0:
  - 264 bytes with shift 9
  - 528 bytes with shift 10
  - 1056 bytes with shift 11
- R6: Identifier 0x1F2700 gives 8192 pages of 528 bytes with shift 10 and `pow2_pages` = 0. No status frame is sent for it.
- R7: Any other identifier, including a manufacturer byte other than 0x1F, leads to a status frame. The result is then decoded by the legacy rules.
- R8: A legacy status of 0x00 or 0xFF gives result 2 (no device), with all geometry outputs 0.
- R9: The legacy decode uses status & 0x3C, always with `pow2_pages` = 0:

  | status & 0x3C | Pages | Bytes per page | Shift |
  |---|---|---|---|
  | 0x0C | 512 | 264 | 9 |
  | 0x14 | 1024 | 264 | 9 |
  | 0x1C | 2048 | 264 | 9 |
  | 0x24 | 4096 | 264 | 9 |
  | 0x2C | 4096 | 528 | 10 |
  | 0x34 | 8192 | 528 | 10 |
  | 0x38 or 0x3C | 8192 | 1056 | 11 |

- R10: Any other legacy code gives result 3 (unsupported), with all geometry outputs 0.
- R11: On success (result 1), `total_bytes` equals page count times page size, and `erase_bytes` equals `page_bytes`.
- R12: `probe_done` and all results hold until a new `probe_start`. A start taken while done clears `probe_done` and `probe_result` in the next cycle and probes again.
- R13: A `probe_start` while a probe is in progress is ignored. This includes a start in the same cycle as the final acknowledge. No extra frame follows, and the running probe completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_start | input | 1 | Request a probe (accepted when idle or done) |
| probe_done | output | 1 | Results valid and held |
| probe_result | output | 2 | 0 none, 1 ok, 2 no device, 3 unsupported |
| page_bytes | output | PGSZ_W | Page size in bytes |
| addr_shift | output | SHIFT_W | Page-address shift |
| page_count | output | PAGES_W | Number of pages |
| pow2_pages | output | 1 | Binary page size in use |
| total_bytes | output | PGSZ_W+PAGES_W | Device size in bytes |
| erase_bytes | output | PGSZ_W | Erase granularity in bytes |
| xfer_req | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_end | output | 1 | Release chip select after this byte |
| xfer_ack | input | 1 | Byte done, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte shifted in |

## Verification
Two events can fall in the same cycle: a new probe request, and the acknowledge of the last status byte that ends a probe. The bench's flash model raises `probe_start` in exactly the cycle of that final acknowledge. Because the block is still busy in that cycle, the request must be dropped. The bench judges this by confirming three things a few cycles later: `probe_done` has risen with the expected geometry, no further frame has appeared on the port, and the result is still held. A second case pokes a start in the middle of the ID frame. The bench then counts frames and opcodes to confirm that the probe neither restarted nor broke.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_OK    = 2'd1,
      RES_NODEV = 2'd2,
      RES_UNSUP = 2'd3
   } res_e;

   // compact geometry: log2 page address shift, log2 page count, binary flag
   typedef struct packed {
      logic [3:0] shift;
      logic [3:0] pages_log;
      logic       pow2;
   } geo_t;

   localparam geo_t GEO_ZERO = '{shift: 4'd0, pages_log: 4'd0, pow2: 1'b0};

   function automatic geo_t mk_geo(input logic [3:0] sh, input logic [3:0] pl,
                                   input logic p2);
      geo_t g;
      g.shift     = sh;
      g.pages_log = pl;
      g.pow2      = p2;
      return g;
   endfunction

endpackage

// File: rtl/sfp_id_decode.sv
module sfp_id_decode
   import sfp_pkg::*;
#(
   parameter logic [7:0] MFR_CODE = 8'h1F
) (
   input  logic [23:0] id_word,
   input  logic        st_pow2,
   output logic        known,
   output logic        needs_status,
   output geo_t        geo
);

   logic [7:0] mfr, dens, ext;
   logic       mfr_ok, in_range, fixed_rev, dual_mode;
   logic [3:0] ext_shift, pl;

   assign mfr  = id_word[23:16];
   assign dens = id_word[15:8];
   assign ext  = id_word[7:0];

   assign mfr_ok    = (mfr == MFR_CODE);
   assign in_range  = (dens >= 8'h22) && (dens <= 8'h28);
   assign fixed_rev = mfr_ok && (dens == 8'h27) && (ext == 8'h00);
   assign dual_mode = mfr_ok && in_range &&
                      (((ext == 8'h00) && (dens != 8'h27)) ||
                       ((dens == 8'h27) && (ext == 8'h01)));

   assign known        = fixed_rev || dual_mode;
   assign needs_status = dual_mode;

   always_comb begin
      ext_shift = 4'd9;
      pl        = 4'd9;
      case (dens)
         8'h22:   begin ext_shift = 4'd9;  pl = 4'd9;  end
         8'h23:   begin ext_shift = 4'd9;  pl = 4'd10; end
         8'h24:   begin ext_shift = 4'd9;  pl = 4'd11; end
         8'h25:   begin ext_shift = 4'd9;  pl = 4'd12; end
         8'h26:   begin ext_shift = 4'd10; pl = 4'd12; end
         8'h27:   begin ext_shift = 4'd10; pl = 4'd13; end
         8'h28:   begin ext_shift = 4'd11; pl = 4'd13; end
         default: begin ext_shift = 4'd9;  pl = 4'd9;  end
      endcase
   end

   always_comb begin
      if (fixed_rev)
         geo = mk_geo(4'd10, 4'd13, 1'b0);
      else if (dual_mode)
         geo = mk_geo(st_pow2 ? ext_shift - 4'd1 : ext_shift, pl, st_pow2);
      else
         geo = GEO_ZERO;
   end

endmodule

// File: rtl/sfp_legacy_decode.sv
module sfp_legacy_decode
   import sfp_pkg::*;
#(
   parameter bit LEGACY_EN = 1'b1
) (
   input  logic [7:0] status,
   output res_e       res,
   output geo_t       geo
);

   logic absent;
   assign absent = (status == 8'h00) || (status == 8'hFF);

   generate
      if (LEGACY_EN) begin : g_legacy
         always_comb begin
            res = RES_OK;
            geo = GEO_ZERO;
            if (absent) begin
               res = RES_NODEV;
            end else begin
               case (status[5:2])
                  4'd3:        geo = mk_geo(4'd9,  4'd9,  1'b0);
                  4'd5:        geo = mk_geo(4'd9,  4'd10, 1'b0);
                  4'd7:        geo = mk_geo(4'd9,  4'd11, 1'b0);
                  4'd9:        geo = mk_geo(4'd9,  4'd12, 1'b0);
                  4'd11:       geo = mk_geo(4'd10, 4'd12, 1'b0);
                  4'd13:       geo = mk_geo(4'd10, 4'd13, 1'b0);
                  4'd14, 4'd15: geo = mk_geo(4'd11, 4'd13, 1'b0);
                  default:     res = RES_UNSUP;
               endcase
            end
         end
      end else begin : g_no_legacy
         assign res = absent ? RES_NODEV : RES_UNSUP;
         assign geo = GEO_ZERO;
      end
   endgenerate

endmodule

// File: rtl/sfp_seq.sv
module sfp_seq #(
   parameter int         ID_BYTES  = 5,
   parameter logic [7:0] OP_ID     = 8'h9F,
   parameter logic [7:0] OP_STATUS = 8'hD7,
   parameter logic [7:0] FILL      = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        xfer_ack,
   input  logic [7:0]  xfer_rx,
   input  logic        id_known,
   input  logic        id_needs_status,
   output logic        xfer_req,
   output logic [7:0]  xfer_tx,
   output logic        xfer_end,
   output logic [23:0] id_word,
   output logic [7:0]  status_byte,
   output logic        accept,
   output logic        commit,
   output logic        path_id,
   output logic        done
);

   localparam int CNT_W = $clog2(ID_BYTES + 1);
   localparam int KEEP  = 3;

   typedef enum logic [2:0] {
      S_IDLE, S_ID_OP, S_ID_RD, S_ID_EV, S_ST_OP, S_ST_RD, S_ST_EV, S_DONE
   } st_e;

   st_e              state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             path_q;
   logic [7:0]       st_q;
   logic             last_id, id_only;

   assign last_id = (cnt_q == CNT_W'(ID_BYTES - 1));
   assign id_only = id_known && !id_needs_status;
   assign accept  = start && ((state_q == S_IDLE) || (state_q == S_DONE));

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_IDLE, S_DONE: if (accept)              state_d = S_ID_OP;
         S_ID_OP:        if (xfer_ack)            state_d = S_ID_RD;
         S_ID_RD:        if (xfer_ack && last_id) state_d = S_ID_EV;
         S_ID_EV:        state_d = id_only ? S_DONE : S_ST_OP;
         S_ST_OP:        if (xfer_ack)            state_d = S_ST_RD;
         S_ST_RD:        if (xfer_ack)            state_d = S_ST_EV;
         S_ST_EV:        state_d = S_DONE;
         default:        state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
         path_q  <= 1'b0;
         st_q    <= 8'h00;
      end else begin
         state_q <= state_d;
         if (accept)
            cnt_q <= '0;
         else if ((state_q == S_ID_RD) && xfer_ack)
            cnt_q <= cnt_q + CNT_W'(1);
         if (state_q == S_ID_EV)
            path_q <= id_known;
         if (accept)
            st_q <= 8'h00;
         else if ((state_q == S_ST_RD) && xfer_ack)
            st_q <= xfer_rx;
      end
   end

   generate
      for (genvar g = 0; g < KEEP; g++) begin : g_cap
         logic [7:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               byte_q <= 8'h00;
            else if ((state_q == S_ID_RD) && xfer_ack && (cnt_q == CNT_W'(g)))
               byte_q <= xfer_rx;
         end
         assign id_word[(KEEP-1-g)*8 +: 8] = byte_q;
      end
   endgenerate

   assign status_byte = st_q;
   assign xfer_req    = (state_q == S_ID_OP) || (state_q == S_ID_RD) ||
                        (state_q == S_ST_OP) || (state_q == S_ST_RD);
   assign xfer_tx     = (state_q == S_ID_OP) ? OP_ID :
                        (state_q == S_ST_OP) ? OP_STATUS : FILL;
   assign xfer_end    = ((state_q == S_ID_RD) && last_id) || (state_q == S_ST_RD);
   assign commit      = ((state_q == S_ID_EV) && id_only) || (state_q == S_ST_EV);
   assign path_id     = (state_q == S_ID_EV) ? 1'b1 : path_q;
   assign done        = (state_q == S_DONE);

endmodule

// File: rtl/sfp_probe.sv
module sfp_probe
   import sfp_pkg::*;
#(
   parameter int         ID_BYTES  = 5,
   parameter int         PGSZ_W    = 11,
   parameter int         PAGES_W   = 14,
   parameter int         SHIFT_W   = 4,
   parameter bit         LEGACY_EN = 1'b1,
   parameter logic [7:0] OP_ID     = 8'h9F,
   parameter logic [7:0] OP_STATUS = 8'hD7,
   parameter logic [7:0] MFR_CODE  = 8'h1F,
   localparam int        SIZE_W    = PGSZ_W + PAGES_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               probe_start,
   output logic               probe_done,
   output logic [1:0]         probe_result,
   output logic [PGSZ_W-1:0]  page_bytes,
   output logic [SHIFT_W-1:0] addr_shift,
   output logic [PAGES_W-1:0] page_count,
   output logic               pow2_pages,
   output logic [SIZE_W-1:0]  total_bytes,
   output logic [PGSZ_W-1:0]  erase_bytes,
   output logic               xfer_req,
   output logic [7:0]         xfer_tx,
   output logic               xfer_end,
   input  logic               xfer_ack,
   input  logic [7:0]         xfer_rx
);

   generate
      if (ID_BYTES < 3 || ID_BYTES > 16) begin : g_bad_idb
         $error("ID_BYTES must lie in 3..16");
      end
      if (PGSZ_W < 11) begin : g_bad_pgsz
         $error("PGSZ_W must hold 1056");
      end
      if (PAGES_W < 14) begin : g_bad_pages
         $error("PAGES_W must hold 8192");
      end
      if (SHIFT_W < 4) begin : g_bad_shift
         $error("SHIFT_W must hold 11");
      end
   endgenerate

   logic [23:0] id_word;
   logic [7:0]  status_byte;
   logic        accept, commit, path_id, seq_done;
   logic        id_known, id_needs_status;
   geo_t        id_geo, leg_geo, sel_geo;
   res_e        leg_res, sel_res;

   sfp_seq #(
      .ID_BYTES (ID_BYTES),
      .OP_ID    (OP_ID),
      .OP_STATUS(OP_STATUS),
      .FILL     (8'h00)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (probe_start),
      .xfer_ack       (xfer_ack),
      .xfer_rx        (xfer_rx),
      .id_known       (id_known),
      .id_needs_status(id_needs_status),
      .xfer_req       (xfer_req),
      .xfer_tx        (xfer_tx),
      .xfer_end       (xfer_end),
      .id_word        (id_word),
      .status_byte    (status_byte),
      .accept         (accept),
      .commit         (commit),
      .path_id        (path_id),
      .done           (seq_done)
   );

   sfp_id_decode #(.MFR_CODE(MFR_CODE)) u_id (
      .id_word     (id_word),
      .st_pow2     (status_byte[0]),
      .known       (id_known),
      .needs_status(id_needs_status),
      .geo         (id_geo)
   );

   sfp_legacy_decode #(.LEGACY_EN(LEGACY_EN)) u_leg (
      .status(status_byte),
      .res   (leg_res),
      .geo   (leg_geo)
   );

   logic [PGSZ_W-1:0]  nb;
   logic [PAGES_W-1:0] np;
   logic [SIZE_W-1:0]  nt;
   logic [SHIFT_W-1:0] ns;

   always_comb begin
      sel_geo = path_id ? id_geo : leg_geo;
      sel_res = path_id ? RES_OK : leg_res;
      nb = '0;
      np = '0;
      nt = '0;
      ns = '0;
      if (sel_res == RES_OK) begin
         if (sel_geo.pow2)
            nb = PGSZ_W'(1) << sel_geo.shift;
         else
            nb = (PGSZ_W'(1) << (sel_geo.shift - 4'd1)) +
                 (PGSZ_W'(1) << (sel_geo.shift - 4'd6));
         np = PAGES_W'(1) << sel_geo.pages_log;
         nt = SIZE_W'(nb) << sel_geo.pages_log;
         ns = SHIFT_W'(sel_geo.shift);
      end
   end

   res_e res_q;

   always_ff @(posedge clk) begin
      if (!rst_n || accept) begin
         res_q       <= RES_NONE;
         page_bytes  <= '0;
         page_count  <= '0;
         total_bytes <= '0;
         addr_shift  <= '0;
         pow2_pages  <= 1'b0;
      end else if (commit) begin
         res_q       <= sel_res;
         page_bytes  <= nb;
         page_count  <= np;
         total_bytes <= nt;
         addr_shift  <= ns;
         pow2_pages  <= (sel_res == RES_OK) && sel_geo.pow2;
      end
   end

   assign probe_result = res_q;
   assign probe_done   = seq_done;
   assign erase_bytes  = page_bytes;

endmodule

// File: rtl/sfp_probe_chk.sv
module sfp_probe_chk #(
   parameter int PGSZ_W  = 11,
   parameter int PAGES_W = 14,
   parameter int SHIFT_W = 4,
   localparam int SIZE_W = PGSZ_W + PAGES_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               probe_start,
   input logic               probe_done,
   input logic [1:0]         probe_result,
   input logic [PGSZ_W-1:0]  page_bytes,
   input logic [SHIFT_W-1:0] addr_shift,
   input logic [PAGES_W-1:0] page_count,
   input logic               pow2_pages,
   input logic [SIZE_W-1:0]  total_bytes,
   input logic               xfer_req,
   input logic [7:0]         xfer_tx,
   input logic               xfer_end,
   input logic               xfer_ack
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx) && $stable(xfer_end)); // R3

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done |-> !xfer_req); // R12

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done && !probe_start |=> probe_done && $stable(probe_result) &&
      $stable(page_bytes) && $stable(page_count) && $stable(total_bytes)); // R12

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done && probe_start |=> !probe_done && probe_result == 2'd0); // R12

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && probe_start |=> !probe_done); // R13

   AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done && probe_result != 2'd1 |->
      page_bytes == '0 && page_count == '0 && total_bytes == '0); // R8

   AST_POW2_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done && pow2_pages |-> page_bytes == (PGSZ_W'(1) << addr_shift)); // R4

   AST_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done && probe_result == 2'd1 |->
      total_bytes == SIZE_W'(page_bytes) * SIZE_W'(page_count)); // R11

endmodule

bind sfp_probe sfp_probe_chk #(
   .PGSZ_W (PGSZ_W),
   .PAGES_W(PAGES_W),
   .SHIFT_W(SHIFT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .probe_start (probe_start),
   .probe_done  (probe_done),
   .probe_result(probe_result),
   .page_bytes  (page_bytes),
   .addr_shift  (addr_shift),
   .page_count  (page_count),
   .pow2_pages  (pow2_pages),
   .total_bytes (total_bytes),
   .xfer_req    (xfer_req),
   .xfer_tx     (xfer_tx),
   .xfer_end    (xfer_end),
   .xfer_ack    (xfer_ack)
);

// File: tb/sfp_probe_tb.sv
module sfp_probe_tb;

   localparam int CLK_NS  = 10;
   localparam int PGSZ_W  = 11;
   localparam int PAGES_W = 14;
   localparam int SHIFT_W = 4;
   localparam int SIZE_W  = PGSZ_W + PAGES_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               tb_start = 1'b0;
   logic               inj_start = 1'b0;
   logic               probe_start;
   logic               probe_done;
   logic [1:0]         probe_result;
   logic [PGSZ_W-1:0]  page_bytes;
   logic [SHIFT_W-1:0] addr_shift;
   logic [PAGES_W-1:0] page_count;
   logic               pow2_pages;
   logic [SIZE_W-1:0]  total_bytes;
   logic [PGSZ_W-1:0]  erase_bytes;
   logic               xfer_req;
   logic [7:0]         xfer_tx;
   logic               xfer_end;
   logic               xfer_ack = 1'b0;
   logic [7:0]         xfer_rx = 8'h00;

   int checks = 0;
   int failures = 0;

   assign probe_start = tb_start | inj_start;

   always #(CLK_NS/2) clk = ~clk;

   sfp_probe u_dut (
      .clk(clk), .rst_n(rst_n), .probe_start(probe_start),
      .probe_done(probe_done), .probe_result(probe_result),
      .page_bytes(page_bytes), .addr_shift(addr_shift),
      .page_count(page_count), .pow2_pages(pow2_pages),
      .total_bytes(total_bytes), .erase_bytes(erase_bytes),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_end(xfer_end),
      .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
   );

   // ---------------- flash model on the byte port ----------------
   logic [7:0] id_mem [5];
   logic [7:0] st_val = 8'h00;
   int         lat = 0;
   bit         inj_en = 1'b0;
   int         pos = 0;
   int         nframes = 0;
   logic [7:0] fop [4];
   int         flen [4];
   int         proto_bad = 0;
   int         fill_bad = 0;
   logic [7:0] cur_op = 8'h00;

   initial begin
      forever begin
         @(negedge clk);
         xfer_ack  = 1'b0;
         inj_start = 1'b0;
         if (rst_n && xfer_req) begin
            logic [7:0] t;
            logic       e;
            logic [7:0] r;
            t = xfer_tx;
            e = xfer_end;
            for (int i = 0; i < lat; i++) begin
               @(negedge clk);
               if (!xfer_req || xfer_tx != t || xfer_end != e) proto_bad++;
            end
            r = 8'hFF;
            if (pos == 0) begin
               cur_op = t;
            end else begin
               if (t != 8'h00) fill_bad++;
               if (cur_op == 8'h9F && pos <= 5) r = id_mem[pos-1];
               else if (cur_op == 8'hD7) r = st_val;
            end
            xfer_rx  = r;
            xfer_ack = 1'b1;
            if (e) begin
               if (nframes < 4) begin
                  fop[nframes]  = cur_op;
                  flen[nframes] = pos + 1;
               end
               nframes++;
               pos = 0;
               if (inj_en && cur_op == 8'hD7) inj_start = 1'b1;
            end else begin
               pos++;
            end
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected results, derived from the requirement tables
   int e_res, e_bytes, e_shift, e_pages, e_pow2, e_stread;

   task automatic expect_geo(input logic [7:0] b0, b1, b2, st);
      bit fixed_rev, dual;
      int eb, es, pb;
      fixed_rev = (b0 == 8'h1F) && (b1 == 8'h27) && (b2 == 8'h00);
      dual = (b0 == 8'h1F) &&
             (((b2 == 8'h00) && (b1 inside {8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h28})) ||
              ((b1 == 8'h27) && (b2 == 8'h01)));
      e_res = 1; e_bytes = 0; e_shift = 0; e_pages = 0; e_pow2 = 0; e_stread = 1;
      if (fixed_rev) begin
         e_bytes = 528; e_shift = 10; e_pages = 8192; e_stread = 0;
      end else if (dual) begin
         eb = 264; es = 9; pb = 256;
         case (b1)
            8'h22: e_pages = 512;
            8'h23: e_pages = 1024;
            8'h24: e_pages = 2048;
            8'h25: e_pages = 4096;
            8'h26: begin e_pages = 4096; eb = 528;  es = 10; pb = 512;  end
            8'h27: begin e_pages = 8192; eb = 528;  es = 10; pb = 512;  end
            default: begin e_pages = 8192; eb = 1056; es = 11; pb = 1024; end
         endcase
         if (st[0]) begin e_bytes = pb; e_shift = es - 1; e_pow2 = 1; end
         else begin e_bytes = eb; e_shift = es; end
      end else if (st == 8'h00 || st == 8'hFF) begin
         e_res = 2;
      end else begin
         case (st & 8'h3C)
            8'h0C: begin e_pages = 512;  e_bytes = 264;  e_shift = 9;  end
            8'h14: begin e_pages = 1024; e_bytes = 264;  e_shift = 9;  end
            8'h1C: begin e_pages = 2048; e_bytes = 264;  e_shift = 9;  end
            8'h24: begin e_pages = 4096; e_bytes = 264;  e_shift = 9;  end
            8'h2C: begin e_pages = 4096; e_bytes = 528;  e_shift = 10; end
            8'h34: begin e_pages = 8192; e_bytes = 528;  e_shift = 10; end
            8'h38, 8'h3C: begin e_pages = 8192; e_bytes = 1056; e_shift = 11; end
            default: e_res = 3;
         endcase
      end
   endtask

   // one full probe: start, wait, check geometry, frames and hold
   task automatic run_probe(input string tag, input logic [7:0] b0, b1, b2,
                            input logic [7:0] st, input int latency,
                            input int poke_at, input bit inject);
      int cyc;
      int frames_at_done;
      logic [PGSZ_W-1:0] held_bytes;
      expect_geo(b0, b1, b2, st);
      id_mem[0] = b0; id_mem[1] = b1; id_mem[2] = b2;
      id_mem[3] = 8'h5A; id_mem[4] = 8'hA5;
      st_val = st; lat = latency; inj_en = inject;
      nframes = 0; proto_bad = 0; fill_bad = 0; pos = 0;
      @(negedge clk); tb_start = 1'b1;
      @(negedge clk); tb_start = 1'b0;
      chk(!probe_done && probe_result == 2'd0, "R12", {tag, " start clears done/result"},
          {probe_done, probe_result}, 0);
      cyc = 0;
      while (!probe_done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         tb_start = (poke_at != 0 && cyc == poke_at);
      end
      tb_start = 1'b0;
      chk(probe_done, "R12", {tag, " done reached"}, probe_done, 1);
      chk(probe_result == 2'(e_res), tag, "result", probe_result, e_res);
      chk(page_bytes == PGSZ_W'(e_bytes), tag, "page_bytes", page_bytes, e_bytes);
      chk(addr_shift == SHIFT_W'(e_shift), tag, "addr_shift", addr_shift, e_shift);
      chk(page_count == PAGES_W'(e_pages), tag, "page_count", page_count, e_pages);
      chk(pow2_pages == e_pow2[0], tag, "pow2_pages", pow2_pages, e_pow2);
      chk(total_bytes == SIZE_W'(e_pages * e_bytes), "R11", {tag, " total_bytes"},
          total_bytes, e_pages * e_bytes);
      chk(erase_bytes == PGSZ_W'(e_bytes), "R11", {tag, " erase_bytes"}, erase_bytes, e_bytes);
      chk(nframes == 1 + e_stread, e_stread ? "R7" : "R6", {tag, " frame count"},
          nframes, 1 + e_stread);
      chk(fop[0] == 8'h9F && flen[0] == 6, "R2", {tag, " ID frame op/len"}, flen[0], 6);
      if (e_stread != 0)
         chk(fop[1] == 8'hD7 && flen[1] == 2, "R4", {tag, " status frame op/len"}, flen[1], 2);
      chk(fill_bad == 0, "R2", {tag, " fill bytes"}, fill_bad, 0);
      chk(proto_bad == 0, "R3", {tag, " request held until ack"}, proto_bad, 0);
      frames_at_done = nframes;
      held_bytes = page_bytes;
      repeat (8) @(negedge clk);
      chk(probe_done && page_bytes == held_bytes && nframes == frames_at_done,
          inject ? "R13" : "R12", {tag, " held after done"}, nframes, frames_at_done);
      inj_en = 1'b0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!probe_done && probe_result == 2'd0 && !xfer_req, "R1", "reset control",
          {probe_done, probe_result, xfer_req}, 0);
      chk(page_bytes == '0 && page_count == '0 && total_bytes == '0 &&
          addr_shift == '0 && !pow2_pages, "R1", "reset geometry", page_bytes, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!probe_done && !xfer_req, "R1", "idle after reset", xfer_req, 0);
   endtask

   initial begin : main
      t_reset();
      run_probe("R4 pow2 0x24",     8'h1F, 8'h24, 8'h00, 8'h81, 0, 0, 1'b0);
      run_probe("R4 pow2 0x28",     8'h1F, 8'h28, 8'h00, 8'h8D, 2, 0, 1'b0);
      run_probe("R4 pow2 0x2701",   8'h1F, 8'h27, 8'h01, 8'h01, 1, 0, 1'b0);
      run_probe("R5 ext 0x26",      8'h1F, 8'h26, 8'h00, 8'hAC, 0, 0, 1'b0);
      run_probe("R5 ext 0x22",      8'h1F, 8'h22, 8'h00, 8'h00, 3, 0, 1'b0);
      run_probe("R6 fixed 0x2700",  8'h1F, 8'h27, 8'h00, 8'h01, 1, 0, 1'b0);
      run_probe("R9 legacy 0x1C",   8'h00, 8'h00, 8'h00, 8'h9C, 0, 0, 1'b0);
      run_probe("R9 legacy 0x38",   8'hC2, 8'h24, 8'h00, 8'hBA, 2, 0, 1'b0);
      run_probe("R9 legacy 0x34",   8'h1F, 8'h27, 8'h05, 8'hB4, 0, 0, 1'b0);
      run_probe("R7 unknown code",  8'h1F, 8'h29, 8'h00, 8'h8C, 1, 0, 1'b0);
      run_probe("R8 status zero",   8'hFF, 8'hFF, 8'hFF, 8'h00, 0, 0, 1'b0);
      run_probe("R8 status ones",   8'h00, 8'h00, 8'h00, 8'hFF, 1, 0, 1'b0);
      run_probe("R10 unsupported",  8'h00, 8'h00, 8'h00, 8'h90, 0, 0, 1'b0);
      run_probe("R13 busy poke",    8'h1F, 8'h25, 8'h00, 8'h00, 3, 4, 1'b0);
      run_probe("R13 final-ack start", 8'h1F, 8'h23, 8'h00, 8'h01, 0, 0, 1'b1);
      run_probe("R9 legacy 0x2C",   8'h00, 8'h00, 8'h00, 8'hAD, 0, 0, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule